// File: doc/BRIEF.md
# ADC Scan-Completion Interrupt Sequencer

This block is the control logic that stands next to a scanning analog-to-digital converter. It decides when the converter may start a scan, and it turns completion strobes into interrupt requests and event pulses. The converter reports each finished scan with a strobe and a group tag. The sequencer raises one single-cycle request for each qualifying completion, so a DMA or transfer engine downstream sees exactly one request per completion.

Three scan modes are supported: single, continuous and group. In group mode the converter alternates between a main group A and a secondary group B. A double-trigger option pairs scans so that the main interrupt fires only after the second scan of a pair. After the module leaves its stop state, a hold-off counter blocks scan starts for one microsecond, given as a number of clock cycles.

Top module: `adc_scan_irq_seq`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, every output is low.
- R2: With `mode_sel` not equal to 2'b10 and `dbl_en` low, every cycle with `done_vld` high gives an `irq_scan_end` pulse one cycle later, whatever `done_grp` holds. `irq_grpb_end` stays low.
- R3: With `dbl_en` high outside group mode, completions are counted in pairs. The first completion of a pair gives no `irq_scan_end`. The second gives one pulse, and the next pair then begins.
- R4: With `mode_sel` = 2'b10 (group) and `dbl_en` low, a completion with `done_grp` = 0 (group A) gives `irq_scan_end`. A completion with `done_grp` = 1 (group B) gives `irq_grpb_end` instead. The two never fire together.
- R5: In group mode with `dbl_en` high, `irq_scan_end` fires on every second group A completion. Each group B completion still gives `irq_grpb_end`, and it does not advance the group A pairing.
- R6: Each completion gives `ev_all` one cycle later. `ev_main` fires for every completion except a group B completion in group mode. `ev_grpb` fires for group B completions in group mode.
- R7: `win_match` gives an `ev_win` pulse one cycle later only when `mode_sel` = 2'b00 (single). In every other mode it is ignored.
- R8: Outside group mode, `sw_trig`, `ext_trig` or `link_trig` gives a `scan_start` pulse with `start_grp_b` low, and the group triggers are ignored. In group mode, `grpa_trig` or `link_trig` starts group A and `grpb_trig` starts group B (`start_grp_b` high). Group A wins when both ask in the same cycle, and `sw_trig` and `ext_trig` are ignored.
- R9: After `mod_stop` falls, triggers are dropped for the first CYC_PER_US cycles. A trigger in the cycle after that is accepted.
- R10: A change of `mode_sel` or `dbl_en` clears the pairing state. A completion in the cycle of the change does not count toward a pair.
- R11: While `mod_stop` is high, every output is low one cycle later and the pairing state is cleared.
- R12: Every output is registered. It is high for exactly one cycle for each input cycle that qualifies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_sel | input | 2 | 00 single, 01 continuous, 10 group, 11 treated as continuous |
| dbl_en | input | 1 | Pair scans before the main interrupt |
| mod_stop | input | 1 | Module stop; clears state and silences outputs |
| sw_trig | input | 1 | Software start request |
| ext_trig | input | 1 | External pin start request |
| link_trig | input | 1 | Start request from the event-link fabric |
| grpa_trig | input | 1 | Group A start request (group mode) |
| grpb_trig | input | 1 | Group B start request (group mode) |
| done_vld | input | 1 | Scan completion strobe |
| done_grp | input | 1 | Group of the completing scan, 0 = A, 1 = B |
| win_match | input | 1 | Window-compare condition met |
| scan_start | output | 1 | Start pulse to the converter |
| start_grp_b | output | 1 | The start pulse is for group B |
| irq_scan_end | output | 1 | Main scan-end interrupt pulse |
| irq_grpb_end | output | 1 | Group B scan-end interrupt pulse |
| ev_main | output | 1 | Event: completion other than group B |
| ev_grpb | output | 1 | Event: group B completion |
| ev_all | output | 1 | Event: any completion |
| ev_win | output | 1 | Event: window match in single mode |

## Verification
The hardest state to reach is a pair left half done when something wipes it. This can be a configuration change or a module stop that arrives after the first completion of a pair. The stimulus leaves a pair half done, toggles `dbl_en` off and on, or raises and lowers `mod_stop`, and then shows that one more completion still raises no interrupt. Only the completion after that one does. The stop case also walks the hold-off window one cycle at a time. It confirms that the last blocked cycle and the first accepted cycle fall where R9 places them.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

    typedef enum logic [1:0] {
        MODE_SINGLE = 2'b00,
        MODE_CONT   = 2'b01,
        MODE_GROUP  = 2'b10,
        MODE_RSVD   = 2'b11
    } scan_mode_e;

    typedef struct packed {
        scan_mode_e mode;
        logic       dbl;
    } scan_cfg_t;

    typedef struct packed {
        logic sw;
        logic ext;
        logic link;
        logic grpa;
        logic grpb;
    } trig_set_t;

    typedef struct packed {
        logic start;
        logic start_b;
        logic irq_main;
        logic irq_b;
        logic ev_main;
        logic ev_b;
        logic ev_all;
        logic ev_win;
    } pulse_set_t;

    function automatic logic mode_is_group(input scan_mode_e m);
        return m == MODE_GROUP;
    endfunction

    function automatic logic mode_is_single(input scan_mode_e m);
        return m == MODE_SINGLE;
    endfunction

endpackage

// File: rtl/adc_stop_holdoff.sv
module adc_stop_holdoff #(
    parameter int CYC_PER_US = 125
) (
    input  logic clk,
    input  logic rst,
    input  logic stop,
    output logic open
);
    localparam int CW = $clog2(CYC_PER_US + 1);
    localparam logic [CW-1:0] LOAD = CW'(CYC_PER_US);

    logic [CW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
        end else if (stop) begin
            remain <= LOAD;
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign open = (remain == '0) && !stop;
endmodule

// File: rtl/adc_start_gate.sv
module adc_start_gate
    import adc_scan_pkg::*;
(
    input  scan_cfg_t cfg,
    input  trig_set_t trg,
    input  logic      open,
    output logic      start,
    output logic      start_b
);
    logic req_a;
    logic req_b;

    always_comb begin
        req_a = 1'b0;
        req_b = 1'b0;
        if (mode_is_group(cfg.mode)) begin
            req_a = trg.grpa | trg.link;
            req_b = trg.grpb;
        end else begin
            req_a = trg.sw | trg.ext | trg.link;
        end
        start   = open & (req_a | req_b);
        start_b = open & !req_a & req_b;
    end
endmodule

// File: rtl/adc_pair_track.sv
module adc_pair_track (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic adv,
    output logic fire
);
    logic half;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            half <= 1'b0;
        end else if (adv) begin
            half <= !half;
        end
    end

    assign fire = adv & half & !clr;
endmodule

// File: rtl/adc_scan_irq_seq.sv
module adc_scan_irq_seq
    import adc_scan_pkg::*;
#(
    parameter int CYC_PER_US = 125
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode_sel,
    input  logic       dbl_en,
    input  logic       mod_stop,
    input  logic       sw_trig,
    input  logic       ext_trig,
    input  logic       link_trig,
    input  logic       grpa_trig,
    input  logic       grpb_trig,
    input  logic       done_vld,
    input  logic       done_grp,
    input  logic       win_match,
    output logic       scan_start,
    output logic       start_grp_b,
    output logic       irq_scan_end,
    output logic       irq_grpb_end,
    output logic       ev_main,
    output logic       ev_grpb,
    output logic       ev_all,
    output logic       ev_win
);
    scan_cfg_t  cfg;
    scan_cfg_t  cfg_q;
    trig_set_t  trg;
    pulse_set_t nxt;
    pulse_set_t out_q;

    logic gate_open;
    logic go;
    logic go_b;
    logic cfg_chg;
    logic dv;
    logic is_b;
    logic pair_adv;
    logic pair_fire;

    assign cfg.mode = scan_mode_e'(mode_sel);
    assign cfg.dbl  = dbl_en;
    assign trg      = '{sw: sw_trig, ext: ext_trig, link: link_trig,
                        grpa: grpa_trig, grpb: grpb_trig};

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '{mode: MODE_SINGLE, dbl: 1'b0};
        end else begin
            cfg_q <= cfg;
        end
    end

    assign cfg_chg = (cfg != cfg_q);

    adc_stop_holdoff #(.CYC_PER_US(CYC_PER_US)) u_hold (
        .clk  (clk),
        .rst  (rst),
        .stop (mod_stop),
        .open (gate_open)
    );

    adc_start_gate u_gate (
        .cfg     (cfg),
        .trg     (trg),
        .open    (gate_open),
        .start   (go),
        .start_b (go_b)
    );

    assign dv       = done_vld & !mod_stop;
    assign is_b     = mode_is_group(cfg.mode) & done_grp;
    assign pair_adv = dv & cfg.dbl & !is_b;

    adc_pair_track u_pair (
        .clk  (clk),
        .rst  (rst),
        .clr  (mod_stop | cfg_chg),
        .adv  (pair_adv),
        .fire (pair_fire)
    );

    always_comb begin
        nxt          = '0;
        nxt.start    = go;
        nxt.start_b  = go_b;
        nxt.irq_main = cfg.dbl ? pair_fire : (dv & !is_b);
        nxt.irq_b    = dv & is_b;
        nxt.ev_main  = dv & !is_b;
        nxt.ev_b     = dv & is_b;
        nxt.ev_all   = dv;
        nxt.ev_win   = win_match & mode_is_single(cfg.mode) & !mod_stop;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q <= nxt;
        end
    end

    assign scan_start   = out_q.start;
    assign start_grp_b  = out_q.start_b;
    assign irq_scan_end = out_q.irq_main;
    assign irq_grpb_end = out_q.irq_b;
    assign ev_main      = out_q.ev_main;
    assign ev_grpb      = out_q.ev_b;
    assign ev_all       = out_q.ev_all;
    assign ev_win       = out_q.ev_win;
endmodule

// File: rtl/adc_scan_irq_chk.sv
module adc_scan_irq_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] mode_sel,
    input logic       mod_stop,
    input logic       done_vld,
    input logic       done_grp,
    input logic       win_match,
    input logic       scan_start,
    input logic       start_grp_b,
    input logic       irq_scan_end,
    input logic       irq_grpb_end,
    input logic       ev_main,
    input logic       ev_grpb,
    input logic       ev_all,
    input logic       ev_win
);
    AST_STOP_SILENT: assert property (@(posedge clk) disable iff (rst)
        $past(mod_stop) |-> !(scan_start | irq_scan_end | irq_grpb_end |
                              ev_main | ev_grpb | ev_all | ev_win)); // R11

    AST_MAIN_NEEDS_DONE: assert property (@(posedge clk) disable iff (rst)
        irq_scan_end |-> $past(done_vld)); // R2

    AST_GRPB_SOURCE: assert property (@(posedge clk) disable iff (rst)
        irq_grpb_end |-> $past(done_vld && done_grp && mode_sel == 2'b10)); // R4

    AST_IRQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(irq_scan_end && irq_grpb_end)); // R4

    AST_ALL_TRACKS_DONE: assert property (@(posedge clk) disable iff (rst)
        ev_all == $past(done_vld && !mod_stop)); // R6

    AST_EV_SPLIT: assert property (@(posedge clk) disable iff (rst)
        ev_all |-> $onehot({ev_main, ev_grpb})); // R6

    AST_WIN_SINGLE_ONLY: assert property (@(posedge clk) disable iff (rst)
        ev_win |-> $past(mode_sel == 2'b00 && win_match)); // R7

    AST_START_B_QUAL: assert property (@(posedge clk) disable iff (rst)
        start_grp_b |-> scan_start); // R8
endmodule

bind adc_scan_irq_seq adc_scan_irq_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .mode_sel     (mode_sel),
    .mod_stop     (mod_stop),
    .done_vld     (done_vld),
    .done_grp     (done_grp),
    .win_match    (win_match),
    .scan_start   (scan_start),
    .start_grp_b  (start_grp_b),
    .irq_scan_end (irq_scan_end),
    .irq_grpb_end (irq_grpb_end),
    .ev_main      (ev_main),
    .ev_grpb      (ev_grpb),
    .ev_all       (ev_all),
    .ev_win       (ev_win)
);

// File: tb/sim_adc_scan_irq_seq.sv
module sim_adc_scan_irq_seq;
    localparam int HOLD = 6;
    localparam logic [7:0] S  = 8'h80, SB = 8'h40, IM = 8'h20, IB = 8'h10;
    localparam logic [7:0] EM = 8'h08, EB = 8'h04, EA = 8'h02, EW = 8'h01;
    localparam logic [4:0] T_SW = 5'b10000, T_EXT = 5'b01000, T_LNK = 5'b00100;
    localparam logic [4:0] T_GA = 5'b00010, T_GB = 5'b00001;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0] mode_sel = 2'b00;
    logic dbl_en = 1'b0, mod_stop = 1'b0;
    logic sw_trig = 1'b0, ext_trig = 1'b0, link_trig = 1'b0;
    logic grpa_trig = 1'b0, grpb_trig = 1'b0;
    logic done_vld = 1'b0, done_grp = 1'b0, win_match = 1'b0;
    logic scan_start, start_grp_b, irq_scan_end, irq_grpb_end;
    logic ev_main, ev_grpb, ev_all, ev_win;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [7:0] exp;
        string      req;
    } sb_item_t;

    sb_item_t sbq[$];
    sb_item_t cur;

    always #4 clk = !clk;

    adc_scan_irq_seq #(.CYC_PER_US(HOLD)) u0 (
        .clk(clk), .rst(rst), .mode_sel(mode_sel), .dbl_en(dbl_en),
        .mod_stop(mod_stop), .sw_trig(sw_trig), .ext_trig(ext_trig),
        .link_trig(link_trig), .grpa_trig(grpa_trig), .grpb_trig(grpb_trig),
        .done_vld(done_vld), .done_grp(done_grp), .win_match(win_match),
        .scan_start(scan_start), .start_grp_b(start_grp_b),
        .irq_scan_end(irq_scan_end), .irq_grpb_end(irq_grpb_end),
        .ev_main(ev_main), .ev_grpb(ev_grpb), .ev_all(ev_all), .ev_win(ev_win)
    );

    function automatic logic [7:0] outs();
        return {scan_start, start_grp_b, irq_scan_end, irq_grpb_end,
                ev_main, ev_grpb, ev_all, ev_win};
    endfunction

    task automatic step(input logic [1:0] m, input logic d, input logic st,
                        input logic [4:0] t, input logic dv, input logic dg,
                        input logic wm, input logic [7:0] e, input string req);
        @(negedge clk);
        mode_sel = m; dbl_en = d; mod_stop = st;
        {sw_trig, ext_trig, link_trig, grpa_trig, grpb_trig} = t;
        done_vld = dv; done_grp = dg; win_match = wm;
        sbq.push_back('{exp: e, req: req});
    endtask

    always @(posedge clk) begin
        #2;
        if (sbq.size() > 0) begin
            cur = sbq.pop_front();
            checks++;
            if (outs() !== cur.exp) begin
                errors++;
                $display("FAIL %s actual %b expected %b", cur.req, outs(), cur.exp);
            end
        end
    end

    initial begin
        #1600000;
        errors++;
        $display("FAIL watchdog actual hung expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (outs() !== 8'h00) begin
            errors++;
            $display("FAIL R1 actual %b expected %b", outs(), 8'h00);
        end
        rst = 1'b0;
        step(2'b00, 0, 0, 5'b0, 0, 0, 0, 8'h00, "R1");
        // starts outside group mode
        step(2'b00, 0, 0, T_SW,  0, 0, 0, S,     "R8");
        step(2'b00, 0, 0, T_EXT, 0, 0, 0, S,     "R8");
        step(2'b00, 0, 0, T_LNK, 0, 0, 0, S,     "R8");
        step(2'b00, 0, 0, T_GA | T_GB, 0, 0, 0, 8'h00, "R8");
        // single completions, tag ignored
        step(2'b00, 0, 0, 5'b0, 1, 0, 0, IM | EM | EA, "R2");
        step(2'b00, 0, 0, 5'b0, 1, 1, 0, IM | EM | EA, "R2");
        step(2'b00, 0, 0, 5'b0, 1, 0, 1, IM | EM | EA | EW, "R12");
        // window match
        step(2'b00, 0, 0, 5'b0, 0, 0, 1, EW,    "R7");
        step(2'b01, 0, 0, 5'b0, 0, 0, 1, 8'h00, "R7");
        // double trigger in continuous mode
        step(2'b01, 1, 0, 5'b0, 0, 0, 0, 8'h00, "R3");
        step(2'b01, 1, 0, 5'b0, 1, 0, 0, EM | EA, "R3");
        step(2'b01, 1, 0, 5'b0, 1, 0, 0, IM | EM | EA, "R3");
        step(2'b01, 1, 0, 5'b0, 1, 0, 0, EM | EA, "R3");
        step(2'b01, 1, 0, 5'b0, 1, 0, 0, IM | EM | EA, "R3");
        // config change drops half pair
        step(2'b01, 1, 0, 5'b0, 1, 0, 0, EM | EA, "R10");
        step(2'b01, 0, 0, 5'b0, 0, 0, 0, 8'h00, "R10");
        step(2'b01, 1, 0, 5'b0, 0, 0, 0, 8'h00, "R10");
        step(2'b01, 1, 0, 5'b0, 1, 0, 0, EM | EA, "R10");
        step(2'b01, 1, 0, 5'b0, 1, 0, 0, IM | EM | EA, "R10");
        // group mode
        step(2'b10, 0, 0, 5'b0, 0, 0, 1, 8'h00, "R7");
        step(2'b10, 0, 0, 5'b0, 1, 0, 0, IM | EM | EA, "R4");
        step(2'b10, 0, 0, 5'b0, 1, 1, 0, IB | EB | EA, "R4");
        step(2'b10, 0, 0, 5'b0, 1, 1, 0, IB | EB | EA, "R6");
        step(2'b10, 0, 0, T_GA,  0, 0, 0, S,      "R8");
        step(2'b10, 0, 0, T_GB,  0, 0, 0, S | SB, "R8");
        step(2'b10, 0, 0, T_GA | T_GB, 0, 0, 0, S, "R8");
        step(2'b10, 0, 0, T_LNK, 0, 0, 0, S,      "R8");
        step(2'b10, 0, 0, T_SW | T_EXT, 0, 0, 0, 8'h00, "R8");
        // group with double trigger
        step(2'b10, 1, 0, 5'b0, 0, 0, 0, 8'h00, "R5");
        step(2'b10, 1, 0, 5'b0, 1, 0, 0, EM | EA, "R5");
        step(2'b10, 1, 0, 5'b0, 1, 1, 0, IB | EB | EA, "R5");
        step(2'b10, 1, 0, 5'b0, 1, 0, 0, IM | EM | EA, "R5");
        // module stop with half pair pending
        step(2'b10, 1, 0, 5'b0, 1, 0, 0, EM | EA, "R11");
        step(2'b10, 1, 1, T_GA, 1, 0, 0, 8'h00, "R11");
        step(2'b10, 1, 1, T_GB, 1, 1, 0, 8'h00, "R11");
        for (int k = 0; k < HOLD; k++)
            step(2'b10, 1, 0, T_GA, 0, 0, 0, 8'h00, "R9");
        step(2'b10, 1, 0, T_GA, 0, 0, 0, S, "R9");
        step(2'b10, 1, 0, 5'b0, 1, 0, 0, EM | EA, "R11");
        step(2'b10, 1, 0, 5'b0, 1, 0, 0, IM | EM | EA, "R11");
        step(2'b10, 1, 0, 5'b0, 0, 0, 0, 8'h00, "R12");
        repeat (3) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule